// File: doc/BRIEF.md
# Matrix Scan-Order Reorder Buffer

This block sits between a pixel stream and a coefficient stream and changes the order in which the samples of an 8×8 matrix travel. Every block holds 64 samples. They are written in one traversal order and read back in another. The block can transpose the matrix, turning row order into column order or the reverse. It can also map between row order and the diagonal zig-zag scan, in either direction. Two 64-entry banks alternate, so a block can be written while the previous one is read, and a continuous stream runs with no idle cycles.

A block opens with a start strobe one cycle ahead of its first sample. The direction and zig-zag selects are taken only in that strobe cycle. Inputs are captured on the falling clock edge and outputs change on the rising edge. The output block is announced by a strobe one cycle ahead of its first sample. An active-low enable marks stall cycles: in those cycles the whole pipeline holds still, so gaps can appear anywhere in either stream.

Top module: `scan_reorder`

## Requirements
- R1: While reset is asserted, and afterwards until the first output block starts, `blk_start_o` is 0 and `data_o` is 0.
- R2: With `zz_i`=0 and either direction, output sample k (k = 8·row + col) is the input sample at row-major position 8·(k mod 8) + k/8. This is a transpose.
- R3: With `zz_i`=1 and `dir_i`=0, output sample k is the input sample at the row-major position of the k-th entry of the zig-zag scan. The scan begins 0, 1, 8, 16, 9, 2, 3, 10 and ends at 63.
- R4: With `zz_i`=1 and `dir_i`=1, output sample p is input sample j, where j is the index at which position p occurs in the zig-zag scan. This is the inverse of R3.
- R5: `dir_i` and `zz_i` are sampled only in the strobe cycle. Changing them during the block has no effect on that block.
- R6: `blk_start_o` is high for exactly one enabled cycle, directly before the first sample of each output block. `data_o` holds its last value between output blocks.
- R7: `blk_start_o` rises at the rising edge that processes the 64th sample of a block. The 64 output samples follow on the next 64 enabled cycles.
- R8: A strobe given together with the 64th sample opens the next block at once. That block's output follows the previous output block with no gap.
- R9: A cycle with `en_n_i`=1 is ignored entirely, including any strobe or data in it, and all outputs and internal state hold.
- R10: A strobe that arrives before the 64th sample discards the partial block and restarts writing at position 0. The sample in the strobe cycle is dropped.
- R11: Samples that arrive while no block is open, after the 64th sample and with no new strobe, are ignored.
- R12: Inputs are captured at the falling clock edge. A value present only around a rising edge is never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs captured on falling edge, outputs launched on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_start_i | input | 1 | Block strobe, one cycle before the first input sample |
| dir_i | input | 1 | Direction: 0 row order in, scan order out; 1 the reverse |
| zz_i | input | 1 | Traversal select: 0 transpose, 1 zig-zag |
| en_n_i | input | 1 | Active-low cycle enable; high marks a stall cycle |
| data_i | input | DW | Input sample |
| data_o | output | DW | Reordered output sample |
| blk_start_o | output | 1 | Output block strobe, one cycle before the first output sample |

## Verification
The assertions assume that a new block is never completed while the previous block is still being read out. This holds because a block needs 64 accepted samples, so two completions are at least 64 enabled cycles apart. They also assume that the enable and the strobe are stable around the falling edge. The stimulus keeps to both conditions. It only ever issues whole blocks or deliberately truncated blocks, and it drives every input just after a falling edge. In the glitch phase it instead holds deliberately wrong values around the rising edge, and drives the real values before the capturing falling edge.

// File: rtl/scan_reorder_pkg.sv
package scan_reorder_pkg;

    typedef enum logic {
        DIR_ROW_TO_SCAN = 1'b0,
        DIR_SCAN_TO_ROW = 1'b1
    } dir_e;

    typedef struct packed {
        dir_e dir;
        logic zz;
    } cmd_t;

    // Row-major position of the k-th entry of the n x n diagonal scan.
    function automatic int zz_position(input int n, input int k);
        int r;
        int c;
        r = 0;
        c = 0;
        for (int s = 0; s < n * n; s++) begin
            if (s < k) begin
                if (((r + c) % 2) == 0) begin
                    if (c == n - 1)      r = r + 1;
                    else if (r == 0)     c = c + 1;
                    else begin r = r - 1; c = c + 1; end
                end else begin
                    if (r == n - 1)      c = c + 1;
                    else if (c == 0)     r = r + 1;
                    else begin r = r + 1; c = c - 1; end
                end
            end
        end
        return r * n + c;
    endfunction

    // Scan index at which row-major position p is visited.
    function automatic int zz_index(input int n, input int p);
        int idx;
        idx = 0;
        for (int k = 0; k < n * n; k++) begin
            if (zz_position(n, k) == p) idx = k;
        end
        return idx;
    endfunction

endpackage

// File: rtl/scan_reorder_capture.sv
module scan_reorder_capture
    import scan_reorder_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strb_i,
    input  cmd_t          cmd_i,
    input  logic          en_n_i,
    input  logic [DW-1:0] data_i,
    output logic          strb_o,
    output cmd_t          cmd_o,
    output logic          en_o,
    output logic [DW-1:0] data_o
);

    typedef struct packed {
        logic          strb;
        cmd_t          cmd;
        logic          en;
        logic [DW-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d.strb = strb_i;
        cap_d.cmd  = cmd_i;
        cap_d.en   = ~en_n_i;
        cap_d.data = data_i;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign strb_o = cap_q.strb;
    assign cmd_o  = cap_q.cmd;
    assign en_o   = cap_q.en;
    assign data_o = cap_q.data;

endmodule

// File: rtl/scan_reorder_wr_ctrl.sv
module scan_reorder_wr_ctrl
    import scan_reorder_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en_i,
    input  logic                      strb_i,
    input  cmd_t                      cmd_i,
    output logic                      we_o,
    output logic [2*$clog2(N)-1:0]    waddr_o,
    output logic                      wbank_o,
    output logic                      done_o,
    output cmd_t                      done_cmd_o
);

    localparam int LOG_N = $clog2(N);
    localparam int AW    = 2 * LOG_N;
    localparam logic [AW-1:0] LAST = AW'(N * N - 1);

    typedef struct packed {
        logic [AW-1:0] idx;
        logic          writing;
        logic          bank;
        cmd_t          cmd;
    } wr_t;

    wr_t  wr_d, wr_q;
    logic we_d;
    logic done_d;

    always_comb begin
        wr_d   = wr_q;
        we_d   = 1'b0;
        done_d = 1'b0;
        if (en_i) begin
            if (wr_q.writing && (!strb_i || wr_q.idx == LAST)) begin
                we_d = 1'b1;
                if (wr_q.idx == LAST) begin
                    done_d     = 1'b1;
                    wr_d.writing = 1'b0;
                    wr_d.bank  = ~wr_q.bank;
                end else begin
                    wr_d.idx = wr_q.idx + AW'(1);
                end
            end
            if (strb_i) begin
                wr_d.writing = 1'b1;
                wr_d.idx     = '0;
                wr_d.cmd     = cmd_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    assign we_o       = we_d;
    assign waddr_o    = wr_q.idx;
    assign wbank_o    = wr_q.bank;
    assign done_o     = done_d;
    assign done_cmd_o = wr_q.cmd;

    // R10: a strobe always restarts the write position at zero
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && strb_i) |=> (wr_q.writing && wr_q.idx == '0));

    // R7: each accepted sample moves the write position by one
    p_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && wr_q.writing && !strb_i && wr_q.idx != LAST)
        |=> (wr_q.idx == AW'($past(wr_q.idx) + AW'(1))));

    // R5: the latched command only changes at a strobe
    p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_i && strb_i) |=> $stable(wr_q.cmd));

    // R11: without a strobe no block opens
    p_idle_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_q.writing && !(en_i && strb_i)) |=> !wr_q.writing);

endmodule

// File: rtl/scan_reorder_store.sv
module scan_reorder_store #(
    parameter int DW    = 12,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic          wbank_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rbank_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] mem_q [2*DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[{wbank_i, waddr_i}] <= wdata_i;
    end

    assign rdata_o = mem_q[{rbank_i, raddr_i}];

endmodule

// File: rtl/scan_reorder_rd_ctrl.sv
module scan_reorder_rd_ctrl
    import scan_reorder_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en_i,
    input  logic                      start_i,
    input  logic                      start_bank_i,
    input  cmd_t                      start_cmd_i,
    input  logic [DW-1:0]             rdata_i,
    output logic                      rbank_o,
    output logic [2*$clog2(N)-1:0]    raddr_o,
    output logic [DW-1:0]             data_o,
    output logic                      strb_o
);

    localparam int LOG_N = $clog2(N);
    localparam int AW    = 2 * LOG_N;
    localparam int DEPTH = N * N;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] idx;
        logic          active;
        logic          bank;
        cmd_t          cmd;
        logic          strb;
        logic [DW-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    logic [AW-1:0] lut_fwd [DEPTH];
    logic [AW-1:0] lut_inv [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_lut
        assign lut_fwd[g] = AW'(zz_position(N, g));
        assign lut_inv[g] = AW'(zz_index(N, g));
    end

    logic [AW-1:0] addr_map;

    always_comb begin
        if (!rd_q.cmd.zz)
            addr_map = {rd_q.idx[LOG_N-1:0], rd_q.idx[AW-1:LOG_N]};
        else if (rd_q.cmd.dir == DIR_ROW_TO_SCAN)
            addr_map = lut_fwd[rd_q.idx];
        else
            addr_map = lut_inv[rd_q.idx];
    end

    always_comb begin
        rd_d = rd_q;
        if (en_i) begin
            rd_d.strb = start_i;
            if (rd_q.active) begin
                rd_d.data = rdata_i;
                rd_d.idx  = rd_q.idx + AW'(1);
                if (rd_q.idx == LAST) rd_d.active = 1'b0;
            end
            if (start_i) begin
                rd_d.active = 1'b1;
                rd_d.idx    = '0;
                rd_d.bank   = start_bank_i;
                rd_d.cmd    = start_cmd_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rbank_o = rd_q.bank;
    assign raddr_o = addr_map;
    assign data_o  = rd_q.data;
    assign strb_o  = rd_q.strb;

    // R6: a completed block starts readout from position zero
    p_start_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && start_i) |=> (rd_q.active && rd_q.idx == '0 && rd_q.strb));

    // R6: the output strobe lasts one enabled cycle
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && rd_q.strb) |=> !rd_q.strb);

    // R9: a stalled cycle leaves the outputs untouched
    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(rd_q.data) && $stable(rd_q.strb) && $stable(rd_q.idx)));

endmodule

// File: rtl/scan_reorder.sv
module scan_reorder
    import scan_reorder_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_start_i,
    input  logic          dir_i,
    input  logic          zz_i,
    input  logic          en_n_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o,
    output logic          blk_start_o
);

    localparam int LOG_N = $clog2(N);
    localparam int AW    = 2 * LOG_N;
    localparam int DEPTH = N * N;

    cmd_t          in_cmd;
    logic          cap_strb;
    cmd_t          cap_cmd;
    logic          cap_en;
    logic [DW-1:0] cap_data;

    logic          we;
    logic [AW-1:0] waddr;
    logic          wbank;
    logic          done;
    cmd_t          done_cmd;

    logic          rbank;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rdata;

    always_comb begin
        in_cmd.dir = dir_e'(dir_i);
        in_cmd.zz  = zz_i;
    end

    scan_reorder_capture #(.DW(DW)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb_i (blk_start_i),
        .cmd_i  (in_cmd),
        .en_n_i (en_n_i),
        .data_i (data_i),
        .strb_o (cap_strb),
        .cmd_o  (cap_cmd),
        .en_o   (cap_en),
        .data_o (cap_data)
    );

    scan_reorder_wr_ctrl #(.N(N)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (cap_en),
        .strb_i     (cap_strb),
        .cmd_i      (cap_cmd),
        .we_o       (we),
        .waddr_o    (waddr),
        .wbank_o    (wbank),
        .done_o     (done),
        .done_cmd_o (done_cmd)
    );

    scan_reorder_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .we_i    (we),
        .wbank_i (wbank),
        .waddr_i (waddr),
        .wdata_i (cap_data),
        .rbank_i (rbank),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    scan_reorder_rd_ctrl #(.N(N), .DW(DW)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (cap_en),
        .start_i      (done),
        .start_bank_i (wbank),
        .start_cmd_i  (done_cmd),
        .rdata_i      (rdata),
        .rbank_o      (rbank),
        .raddr_o      (raddr),
        .data_o       (data_o),
        .strb_o       (blk_start_o)
    );

    // R8: the bank being read is never the bank being written
    p_bank_split_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && we && u_rd.rd_q.active) |-> (wbank != rbank));

endmodule

// File: tb/scan_reorder_test.sv
module scan_reorder_test;

    logic        clk;
    logic        rst_n;
    logic        blk_start_i;
    logic        dir_i;
    logic        zz_i;
    logic        en_n_i;
    logic [11:0] data_i;
    logic [11:0] data_o;
    logic        blk_start_o;

    scan_reorder #(.N(8), .DW(12)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_start_i (blk_start_i),
        .dir_i       (dir_i),
        .zz_i        (zz_i),
        .en_n_i      (en_n_i),
        .data_i      (data_i),
        .data_o      (data_o),
        .blk_start_o (blk_start_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    string cur_tag  = "R1";

    // behavioural reference state
    int   zzord [64];
    int   zzinv [64];
    int   wbuf  [64];
    int   rbuf  [64];
    bit   wr_act = 0;
    int   widx = 0;
    bit   wdir = 0, wzz = 0;
    bit   rd_act = 0;
    int   rk = 0;
    bit   rdir = 0, rzz = 0;
    bit   m_strb = 0;
    int   m_data = 0;
    bit   p_s = 0, p_en = 0, p_dir = 0, p_zz = 0;
    int   p_d = 0;

    task automatic chk(input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", cur_tag, what, got, exp, $time);
        end
    endtask

    function automatic int src_of(input bit dir, input bit zz, input int k);
        if (!zz)       return (k % 8) * 8 + k / 8;
        else if (!dir) return zzord[k];
        else           return zzinv[k];
    endfunction

    task automatic model_tick();
        bit nstrb;
        int ndata;
        if (p_en) begin
            nstrb = 0;
            ndata = m_data;
            if (rd_act) begin
                ndata = rbuf[src_of(rdir, rzz, rk)];
                rk++;
                if (rk == 64) rd_act = 0;
            end
            if (wr_act && (!p_s || widx == 63)) begin
                wbuf[widx] = p_d;
                if (widx == 63) begin
                    for (int i = 0; i < 64; i++) rbuf[i] = wbuf[i];
                    rdir = wdir; rzz = wzz;
                    rd_act = 1; rk = 0; nstrb = 1;
                    wr_act = 0;
                end else begin
                    widx++;
                end
            end
            if (p_s) begin
                wr_act = 1; widx = 0; wdir = p_dir; wzz = p_zz;
            end
            m_strb = nstrb;
            m_data = ndata;
        end
    endtask

    task automatic drive(input bit s, input int d, input bit dir, input bit zz, input bit en_n);
        blk_start_i = s;
        data_i      = 12'(d);
        dir_i       = dir;
        zz_i        = zz;
        en_n_i      = en_n;
    endtask

    // entered just after a falling edge; leaves just after the next one
    task automatic step(input bit s, input int d, input bit dir, input bit zz,
                        input bit en_n, input bit glitch);
        if (glitch) drive(~s, d ^ 12'hfff, ~dir, ~zz, ~en_n);
        else        drive(s, d, dir, zz, en_n);
        @(posedge clk);
        model_tick();
        p_s = s; p_d = d % 4096; p_dir = dir; p_zz = zz; p_en = !en_n;
        #1;
        if (glitch) drive(s, d, dir, zz, en_n);
        @(negedge clk);
        chk("blk_start_o", int'(blk_start_o), int'(m_strb));
        chk("data_o", int'(data_o), m_data);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    // one block of 64 samples; optional leading strobe, gaps, command scrambling,
    // and a chained strobe on the last sample carrying the next block's command
    task automatic block(input int base, input bit dir, input bit zz, input bit lead,
                         input int gap, input bit scramble, input bit glitch,
                         input bit chain, input bit ndir, input bit nzz);
        if (lead) step(1, 4095, dir, zz, 0, glitch);
        for (int k = 0; k < 64; k++) begin
            if (gap > 0 && (k % gap) == gap - 1)
                step(1, 4000 + k, ~dir, ~zz, 1, 0);
            if (k == 63 && chain)
                step(1, base + k, ndir, nzz, 0, glitch);
            else if (scramble)
                step(0, base + k, ~dir, ~zz, 0, glitch);
            else
                step(0, base + k, dir, zz, 0, glitch);
        end
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        int r;
        int c;
        int n;
        n = 0;
        for (int s = 0; s < 15; s++) begin
            for (int j = 0; j < 8; j++) begin
                r = (s % 2 == 0) ? ((s < 8 ? s : 7) - j) : ((s < 8 ? 0 : s - 7) + j);
                c = s - r;
                if (r >= 0 && r < 8 && c >= 0 && c < 8) begin
                    zzord[n] = r * 8 + c;
                    n++;
                end
            end
        end
        for (int k = 0; k < 64; k++) zzinv[zzord[k]] = k;
    end

    initial begin
        rst_n = 0;
        drive(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        cur_tag = "R1";
        chk("blk_start_o in reset", int'(blk_start_o), 0);
        chk("data_o in reset", int'(data_o), 0);
        #1 rst_n = 1;
        idle(4);

        // transpose, then zig-zag forward, then zig-zag inverse, chained back to back
        cur_tag = "R2 R7";
        block(100, 0, 0, 1, 0, 0, 0, 1, 0, 1);
        cur_tag = "R3 R8";
        block(300, 0, 1, 0, 0, 0, 0, 1, 1, 1);
        cur_tag = "R4 R8";
        block(500, 1, 1, 0, 0, 0, 0, 1, 1, 0);
        // commands toggled during the block must be ignored
        cur_tag = "R5 R2";
        block(700, 1, 0, 0, 0, 1, 0, 0, 0, 0);
        cur_tag = "R6";
        idle(70);

        // stall cycles carrying strobes and junk during input and drain
        cur_tag = "R9";
        block(900, 0, 1, 1, 3, 0, 0, 0, 0, 0);
        for (int i = 0; i < 70; i++) step(i % 4 == 1, 3000, 1, 0, (i % 4 == 1) ? 1 : 0, 0);

        // partial block cut short by a fresh strobe
        cur_tag = "R10";
        step(1, 0, 1, 1, 0, 0);
        for (int k = 0; k < 20; k++) step(0, 1500 + k, 1, 1, 0, 0);
        block(1700, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        idle(70);

        // samples with no open block are dropped
        cur_tag = "R11";
        for (int k = 0; k < 40; k++) step(0, 2200 + k, 0, 1, 0, 0);
        block(2400, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        idle(70);

        // wrong values held around the rising edge
        cur_tag = "R12";
        block(2600, 1, 1, 1, 0, 0, 1, 0, 0, 0);
        idle(70);

        finished = 1;
        report();
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

endmodule